// File: doc/BRIEF.md
# Clock Source Switch Controller

This block chooses the system clock from one of two free-running sources: a primary oscillator, whose output already includes any frequency multiplication, and an internal RC oscillator. A two-bit select input names the wanted source. The block drives the enable line of each oscillator. Before the primary source is used, the block counts a fixed number of its cycles as a start-up timer, and when the PLL is in use it also waits a lock interval. Only then does it hand the system clock over to the primary source. A status flag goes high once the system is really running on the primary source.

The control logic runs on the internal oscillator clock. While the primary oscillator starts, the system clock keeps coming from the internal oscillator, so the core never stalls during the wait. The handover goes through a glitch-free multiplexer. Each source has its own gate. A gate is synchronized in its own clock domain and changes state only while that clock is low. The new source's gate opens only after the old source's gate has closed.

Top module: `csw_clock_switch`

## Requirements
- R1: During and after reset the target is the primary source: `pri_osc_en` and `rc_osc_en` are 1, `osc_ready` is 0, and `sys_clk` carries the internal clock until the start-up wait ends.
- R2: A `sel` value of 2'b11 selects the internal oscillator. Once that switch completes, `pri_osc_en` is 0, `osc_ready` is 0 and `sys_clk` carries the internal clock.
- R3: When the primary source is selected again after running on the internal oscillator, `sys_clk` keeps carrying the internal clock for the whole start-up wait.
- R4: The system clock is not switched to the primary source until at least `OST_CYCLES` (default 1024) primary-clock periods have elapsed after `pri_osc_en` rises. `osc_ready` rises within a bounded number of synchronizer cycles after that.
- R5: When `pll_en` is 1, a further `LOCK_CYCLES` internal-clock periods elapse after the start-up count and before the switch.
- R6: `osc_ready` rises only once the primary gate is open and the internal gate is closed. From then on `sys_clk` carries the primary clock.
- R7: While running on the primary source, `rc_osc_en` stays 1 if `wdt_en` or `fscm_en` is 1, and is 0 otherwise.
- R8: The two source gates are never open together, and `sys_clk` shows no high or low phase shorter than the high phase of the faster source.
- R9: If `sel` returns to 2'b11 before a start-up wait finishes, the wait is abandoned: `osc_ready` stays 0 and `pri_osc_en` falls. A later selection of the primary source runs the full count again.
- R10: Every `sel` value other than 2'b11 (2'b00, 2'b01, 2'b10) selects the primary source in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Raw internal RC oscillator clock; also clocks the control logic |
| clk_pri | input | 1 | Raw primary oscillator clock (after any PLL) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Source select; 2'b11 = internal oscillator, any other value = primary |
| pll_en | input | 1 | Adds the PLL lock wait after the start-up count |
| wdt_en | input | 1 | Watchdog enabled; keeps the internal oscillator running |
| fscm_en | input | 1 | Fail-safe clock monitor enabled; keeps the internal oscillator running |
| sys_clk | output | 1 | Glitch-free system clock |
| pri_osc_en | output | 1 | Enable line for the primary oscillator |
| rc_osc_en | output | 1 | Enable line for the internal oscillator |
| osc_ready | output | 1 | Start-up status: 1 when the system runs on the primary source |

## Verification
The sources run at two unrelated periods, 20 ns for the internal clock and 14 ns for the primary, so the width of every high phase of the system clock shows which source drove it. Returns to the primary source are tried with the PLL off and on, and with each monitor-enable combination, so each run tells apart a plain start-up count, an added lock wait, and the correct internal-oscillator enable. All three primary select codes are used, which separates the 2'b11 decode from a decode on a single bit. An abandoned start-up is followed by a full restart, which shows whether a partial count survives the abandon.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;

  typedef enum logic [2:0] {
    ST_RC   = 3'd0,  // running on internal clock, primary off
    ST_OST  = 3'd1,  // primary enabled, start-up count in progress
    ST_LOCK = 3'd2,  // start-up done, waiting for PLL lock
    ST_SWP  = 3'd3,  // handing over to primary
    ST_PRI  = 3'd4,  // running on primary
    ST_SWR  = 3'd5   // handing over to internal
  } csw_state_e;

  function automatic logic sel_is_rc(input logic [1:0] sel);
    return sel == 2'b11;
  endfunction

  function automatic logic rc_needed(input csw_state_e st, input logic wdt,
                                     input logic fscm, input logic want_rc);
    return (st != ST_PRI) || wdt || fscm || want_rc;
  endfunction

endpackage

// File: rtl/csw_sync2.sv
`timescale 1ns/1ps
module csw_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/csw_ost_timer.sv
`timescale 1ns/1ps
module csw_ost_timer #(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk_pri,
  input  logic rst_n,
  input  logic enable,
  output logic done
);
  localparam int CW = $clog2(OST_CYCLES + 1);

  logic          en_s;
  logic [CW-1:0] cnt;

  csw_sync2 u_en_sync (.clk(clk_pri), .rst_n(rst_n), .d(enable), .q(en_s));

  // Count primary edges while the synchronized enable is high
  always_ff @(posedge clk_pri or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!en_s) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == CW'(OST_CYCLES - 1)) done <= 1'b1;
      else                            cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/csw_gate_branch.sv
`timescale 1ns/1ps
module csw_gate_branch (
  input  logic clk_src,
  input  logic rst_n,
  input  logic req,
  output logic gate_on,
  output logic clk_out
);
  logic stage1;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) stage1 <= 1'b0;
    else        stage1 <= req;
  end

  // Second stage on the falling edge: the gate moves only while clk_src is low
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) gate_on <= 1'b0;
    else        gate_on <= stage1;
  end

  assign clk_out = clk_src & gate_on;
endmodule

// File: rtl/csw_clock_switch.sv
`timescale 1ns/1ps
module csw_clock_switch
  import csw_pkg::*;
#(
  parameter int OST_CYCLES  = 1024,
  parameter int LOCK_CYCLES = 16000
) (
  input  logic       clk_rc,
  input  logic       clk_pri,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       pll_en,
  input  logic       wdt_en,
  input  logic       fscm_en,
  output logic       sys_clk,
  output logic       pri_osc_en,
  output logic       rc_osc_en,
  output logic       osc_ready
);
  localparam int LW = $clog2(LOCK_CYCLES + 1);

  csw_state_e    state_q, state_n;
  logic [LW-1:0] lock_cnt;
  logic          want_rc;
  logic          ost_done, ost_done_s;
  logic          lock_done;
  logic          mux_pri;
  logic          pri_on_s;
  logic          gate_rc, gate_pri;
  logic [1:0]    src_clk, want_src, req_src, gate_src, out_src;

  assign want_rc   = sel_is_rc(sel);
  assign lock_done = (state_q == ST_LOCK) && (lock_cnt == LW'(LOCK_CYCLES - 1));
  assign mux_pri   = (state_q == ST_SWP) || (state_q == ST_PRI);

  // Start-up timer in the primary domain, result brought back
  csw_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk_pri(clk_pri), .rst_n(rst_n), .enable(pri_osc_en), .done(ost_done));
  csw_sync2 u_done_sync (.clk(clk_rc), .rst_n(rst_n), .d(ost_done), .q(ost_done_s));

  // Glitch-free mux: index 0 = internal, index 1 = primary
  assign src_clk  = {clk_pri, clk_rc};
  assign want_src = {mux_pri, ~mux_pri};

  for (genvar gi = 0; gi < 2; gi++) begin : g_branch
    assign req_src[gi] = want_src[gi] & ~gate_src[1-gi];
    csw_gate_branch u_br (
      .clk_src(src_clk[gi]), .rst_n(rst_n), .req(req_src[gi]),
      .gate_on(gate_src[gi]), .clk_out(out_src[gi]));
  end

  assign gate_rc  = gate_src[0];
  assign gate_pri = gate_src[1];
  assign sys_clk  = |out_src;

  csw_sync2 u_pri_sync (.clk(clk_rc), .rst_n(rst_n), .d(gate_pri), .q(pri_on_s));

  // Control sequence
  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_RC:   if (!want_rc && !ost_done_s) state_n = ST_OST;
      ST_OST:  if (want_rc)                 state_n = ST_RC;
               else if (ost_done_s)         state_n = pll_en ? ST_LOCK : ST_SWP;
      ST_LOCK: if (want_rc)                 state_n = ST_RC;
               else if (lock_done)          state_n = ST_SWP;
      ST_SWP:  if (want_rc)                 state_n = ST_SWR;
               else if (pri_on_s)           state_n = ST_PRI;
      ST_PRI:  if (want_rc)                 state_n = ST_SWR;
      ST_SWR:  if (gate_rc)                 state_n = ST_RC;
      default:                              state_n = ST_RC;
    endcase
  end

  always_ff @(posedge clk_rc or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_OST;
      lock_cnt  <= '0;
      osc_ready <= 1'b0;
    end else begin
      state_q  <= state_n;
      lock_cnt <= (state_q == ST_LOCK) ? lock_cnt + 1'b1 : '0;
      if (state_n == ST_PRI)     osc_ready <= 1'b1;
      else if (state_n == ST_RC) osc_ready <= 1'b0;
    end
  end

  assign pri_osc_en = (state_q != ST_RC);
  assign rc_osc_en  = rc_needed(state_q, wdt_en, fscm_en, want_rc);

endmodule

// File: rtl/csw_clock_switch_chk.sv
`timescale 1ns/1ps
module csw_clock_switch_chk (
  input logic clk_rc,
  input logic rst_n,
  input logic pll_en,
  input logic wdt_en,
  input logic fscm_en,
  input logic pri_osc_en,
  input logic rc_osc_en,
  input logic osc_ready,
  input logic mux_pri,
  input logic ost_done_s,
  input logic lock_done,
  input logic gate_rc,
  input logic gate_pri
);
  AST_GATES_EXCLUSIVE: assert property (@(posedge clk_rc) disable iff (!rst_n)
    !(gate_rc && gate_pri)); // R8
  AST_SWITCH_AFTER_OST: assert property (@(posedge clk_rc) disable iff (!rst_n)
    $rose(mux_pri) |-> ost_done_s); // R4
  AST_SWITCH_AFTER_LOCK: assert property (@(posedge clk_rc) disable iff (!rst_n)
    ($rose(mux_pri) && pll_en) |-> $past(lock_done)); // R5
  AST_READY_ON_PRIMARY: assert property (@(posedge clk_rc) disable iff (!rst_n)
    $rose(osc_ready) |-> (gate_pri && !gate_rc)); // R6
  AST_PRI_OFF_STATE: assert property (@(posedge clk_rc) disable iff (!rst_n)
    !pri_osc_en |-> (!osc_ready && gate_rc && !gate_pri)); // R2
  AST_RC_STOP_SAFE: assert property (@(posedge clk_rc) disable iff (!rst_n)
    !rc_osc_en |-> (gate_pri && !wdt_en && !fscm_en)); // R7
  AST_PRI_GATE_ENABLED: assert property (@(posedge clk_rc) disable iff (!rst_n)
    gate_pri |-> pri_osc_en); // R3
endmodule

bind csw_clock_switch csw_clock_switch_chk u_chk (
  .clk_rc(clk_rc), .rst_n(rst_n), .pll_en(pll_en), .wdt_en(wdt_en),
  .fscm_en(fscm_en), .pri_osc_en(pri_osc_en), .rc_osc_en(rc_osc_en),
  .osc_ready(osc_ready), .mux_pri(mux_pri), .ost_done_s(ost_done_s),
  .lock_done(lock_done), .gate_rc(gate_rc), .gate_pri(gate_pri));

// File: tb/csw_clock_switch_tb_top.sv
`timescale 1ns/1ps
module csw_clock_switch_tb_top;
  localparam int  OST    = 1024;
  localparam int  LOCK   = 40;
  localparam real T_RC   = 20.0;  // 50 MHz internal clock
  localparam real T_PRI  = 14.0;  // unrelated primary clock
  localparam real SLACK  = 300.0;
  localparam real PRI_HI = 8.5;   // high phases below this come from primary

  logic clk_rc = 1'b0, clk_pri = 1'b0, rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic pll_en = 1'b0, wdt_en = 1'b0, fscm_en = 1'b0;
  logic sys_clk, pri_osc_en, rc_osc_en, osc_ready;

  int  n_vec = 0, n_err = 0;
  bit  done_flag = 1'b0;
  real t_rise = 0.0, t_fall = 0.0, last_hi = 0.0, min_w = 1.0e9;
  int  pri_pulses = 0;

  initial forever #(T_RC/2)  clk_rc  = ~clk_rc;
  initial forever #(T_PRI/2) clk_pri = ~clk_pri;

  csw_clock_switch #(.OST_CYCLES(OST), .LOCK_CYCLES(LOCK)) dut_i (
    .clk_rc(clk_rc), .clk_pri(clk_pri), .rst_n(rst_n), .sel(sel),
    .pll_en(pll_en), .wdt_en(wdt_en), .fscm_en(fscm_en), .sys_clk(sys_clk),
    .pri_osc_en(pri_osc_en), .rc_osc_en(rc_osc_en), .osc_ready(osc_ready));

  // Phase-width monitor on the system clock
  always @(posedge sys_clk) begin
    if (t_fall > 0.0 && ($realtime - t_fall) < min_w) min_w = $realtime - t_fall;
    t_rise = $realtime;
  end
  always @(negedge sys_clk) begin
    last_hi = $realtime - t_rise;
    if (last_hi < min_w) min_w = last_hi;
    if (last_hi < PRI_HI) pri_pulses++;
    t_fall = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_rc);
    n_vec++; n_err++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  // R1, R4, R6, R7: start-up out of reset
  task automatic t_reset();
    real t0, d;
    repeat (4) @(posedge clk_rc);
    #3;
    chk(osc_ready == 1'b0, "R1", "ready in reset", int'(osc_ready), 0);
    chk(pri_osc_en == 1'b1, "R1", "pri_en in reset", int'(pri_osc_en), 1);
    chk(rc_osc_en == 1'b1, "R1", "rc_en in reset", int'(rc_osc_en), 1);
    @(negedge clk_rc); rst_n = 1'b1; t0 = $realtime;
    #(OST*T_PRI/2);
    chk(osc_ready == 1'b0, "R1", "ready mid start-up", int'(osc_ready), 0);
    chk(last_hi > PRI_HI, "R1", "sys_clk high ns x10 mid start-up", int'(last_hi*10), 100);
    wait (osc_ready);
    d = $realtime - t0;
    chk(d >= OST*T_PRI && d <= OST*T_PRI + SLACK, "R4", "reset start-up ns",
        int'(d), int'(OST*T_PRI));
    repeat (10) @(posedge clk_rc); #3;
    chk(last_hi < PRI_HI, "R6", "sys_clk high ns x10 on primary", int'(last_hi*10), 70);
    chk(rc_osc_en == 1'b0, "R7", "rc_en no monitors", int'(rc_osc_en), 0);
  endtask

  // R2: move to the internal oscillator
  task automatic t_to_rc();
    @(negedge clk_rc); sel = 2'b11;
    wait (pri_osc_en == 1'b0);
    #3;
    chk(osc_ready == 1'b0, "R2", "ready after rc switch", int'(osc_ready), 0);
    repeat (6) @(posedge clk_rc); #3;
    chk(last_hi > PRI_HI, "R2", "sys_clk high ns x10 on rc", int'(last_hi*10), 100);
    chk(rc_osc_en == 1'b1, "R2", "rc_en on rc", int'(rc_osc_en), 1);
    chk(pri_osc_en == 1'b0, "R2", "pri_en on rc", int'(pri_osc_en), 0);
  endtask

  // R3..R7, R9, R10: return to the primary source
  task automatic t_to_pri(input logic [1:0] code, input logic pll, input logic wdt,
                          input logic fscm, input string req);
    real t0, d, lo;
    int  p0;
    pll_en = pll; wdt_en = wdt; fscm_en = fscm;
    @(negedge clk_rc); sel = code;
    @(posedge pri_osc_en); t0 = $realtime; p0 = pri_pulses;
    #(OST*T_PRI - 100.0);
    chk(osc_ready == 1'b0, "R3", "ready during start-up", int'(osc_ready), 0);
    chk(pri_pulses == p0, "R3", "primary pulses during start-up", pri_pulses - p0, 0);
    wait (osc_ready);
    d  = $realtime - t0;
    lo = OST*T_PRI + (pll ? LOCK*T_RC : 0.0);
    chk(d >= lo && d <= lo + SLACK, req, "start-up to ready ns", int'(d), int'(lo));
    repeat (10) @(posedge clk_rc); #3;
    chk(last_hi < PRI_HI, req, "sys_clk high ns x10 on primary", int'(last_hi*10), 70);
    chk(rc_osc_en == (wdt | fscm), "R7", "rc_en on primary",
        int'(rc_osc_en), int'(wdt | fscm));
  endtask

  // R9: abandon a start-up part way
  task automatic t_abandon();
    @(negedge clk_rc); sel = 2'b00;
    @(posedge pri_osc_en);
    repeat (200) @(posedge clk_rc);
    @(negedge clk_rc); sel = 2'b11;
    repeat (20) @(posedge clk_rc); #3;
    chk(osc_ready == 1'b0, "R9", "ready after abandon", int'(osc_ready), 0);
    chk(pri_osc_en == 1'b0, "R9", "pri_en after abandon", int'(pri_osc_en), 0);
    chk(last_hi > PRI_HI, "R9", "sys_clk high ns x10 after abandon", int'(last_hi*10), 100);
  endtask

  initial begin
    t_reset();
    t_to_rc();
    t_to_pri(2'b00, 1'b0, 1'b0, 1'b0, "R4");
    t_to_rc();
    t_to_pri(2'b00, 1'b1, 1'b1, 1'b0, "R5");
    t_to_rc();
    t_to_pri(2'b01, 1'b0, 1'b0, 1'b1, "R10");
    t_to_rc();
    t_abandon();
    t_to_pri(2'b10, 1'b0, 1'b0, 1'b0, "R9");
    chk(min_w >= T_PRI/2 - 0.5, "R8", "narrowest sys_clk phase ns x10",
        int'(min_w*10), int'(T_PRI*5));
    finish_run();
  end
endmodule